// File: doc/BRIEF.md
# Burst Memory Self-Test Master

This block is a self-test client for a burst-oriented memory request port. After a go pulse it writes a fixed 16-bit pattern over a programmed address window. Once the whole window is written, it reads the window back and compares each returned word against the pattern. Mismatches are counted. The address of the first bad word is kept for inspection.

Each burst opens with a request phase. The master presents direction and start address with a strobe and holds them until the controller acknowledges. In the data phase a word moves only in cycles where the controller raises its data strobe. The master cannot stall the controller. The master closes a burst itself with a terminate flag on the last word of the window. It also closes a burst after a parameterised number of words, then issues a fresh request that resumes at the next address.

Top module: `mem_selftest`

## Requirements
- R1: After reset, busy, done, req_stb and d_term are low, and err_count and first_bad are zero.
- R2: A go pulse while idle with a nonzero length raises busy from the next cycle. It also raises req_stb with req_wr=1 and req_addr equal to the start address. A pending request holds req_stb, req_wr and req_addr unchanged until req_ack is seen high with req_stb.
- R3: During the write pass, each cycle with d_stb high stores wdata = {8'hAD, addr[7:0]} at the next consecutive address. Every write request of a run comes before any read request of that run.
- R4: In a data phase, a cycle with d_stb low moves no word and advances no address, whatever the length of the gap.
- R5: d_term is high only together with d_stb. It marks the final word of the window and the last word of every BURST-word chunk. Each pass therefore issues ceil(len/BURST) requests, each terminated, and each new request starts at the address after the last word moved.
- R6: During readback, each word that differs from the pattern adds one to err_count, which saturates at 2^EW-1.
- R7: first_bad holds the address of the first mismatching word of the run, and is zero when the run had no mismatch.
- R8: done is a one-cycle pulse in the cycle after the final read word, with busy already low in that cycle.
- R9: A go pulse while busy is ignored: the running test keeps its window and request count.
- R10: A go pulse while idle with length zero issues no request and pulses done in the next cycle with err_count zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Start pulse |
| cfg_base | input | AW | First address of the test window |
| cfg_len | input | LW | Number of words in the window |
| busy | output | 1 | Test running |
| done | output | 1 | One-cycle end-of-test pulse |
| err_count | output | EW | Saturating mismatch count |
| first_bad | output | AW | Address of the first mismatch |
| req_stb | output | 1 | Request valid |
| req_wr | output | 1 | Request direction, 1 write, 0 read |
| req_addr | output | AW | Request start address |
| req_ack | input | 1 | Request accepted by the controller |
| d_stb | input | 1 | Controller data strobe, one word per high cycle |
| d_term | output | 1 | Ends the current burst on this word |
| wdata | output | 16 | Write word |
| rdata | input | 16 | Read word, valid while d_stb is high |

## Verification
The bench builds the block with AW=10, LW=8, EW=3 and BURST=4. With these values one burst covers only four words, so every window longer than that exercises request restarts. A twelve-word window with every read corrupted drives the 3-bit error counter into saturation. The controller model stores writes in a 1024-word array, so the whole address space is checked for stray writes after each run. It inserts data-strobe gaps from per-run 16-bit masks, injects read faults at chosen addresses, and counts requests and terminates.

// File: rtl/mem_selftest.sv
module mem_selftest #(
  parameter int AW = 24,
  parameter int LW = 16,
  parameter int EW = 8,
  parameter int BURST = 64,
  parameter logic [7:0] PAT = 8'hAD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_len,
  output logic          busy,
  output logic          done,
  output logic [EW-1:0] err_count,
  output logic [AW-1:0] first_bad,
  output logic          req_stb,
  output logic          req_wr,
  output logic [AW-1:0] req_addr,
  input  logic          req_ack,
  input  logic          d_stb,
  output logic          d_term,
  output logic [15:0]   wdata,
  input  logic [15:0]   rdata
);
  localparam int BCW = $clog2(BURST + 1);
  localparam logic [EW-1:0] EMAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_WREQ, S_WDAT, S_RREQ, S_RDAT} st_t;
  st_t st;

  logic [AW-1:0]  base;
  logic [LW-1:0]  len, cnt;
  logic [BCW-1:0] bcnt;
  logic [AW-1:0]  addr;
  logic           last_word, chunk_end, in_data, bad;

  assign addr      = base + AW'(cnt);
  assign last_word = (cnt == len - LW'(1));
  assign chunk_end = (bcnt == BCW'(BURST - 1));
  assign in_data   = (st == S_WDAT) || (st == S_RDAT);
  assign busy      = (st != S_IDLE);
  assign req_stb   = (st == S_WREQ) || (st == S_RREQ);
  assign req_wr    = (st == S_WREQ);
  assign req_addr  = addr;
  assign wdata     = {PAT, addr[7:0]};
  assign d_term    = in_data && d_stb && (last_word || chunk_end);
  assign bad       = rdata != {PAT, addr[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      base <= '0;
      len <= '0;
      cnt <= '0;
      bcnt <= '0;
      done <= 1'b0;
      err_count <= '0;
      first_bad <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          err_count <= '0;
          first_bad <= '0;
          base <= cfg_base;
          len <= cfg_len;
          cnt <= '0;
          bcnt <= '0;
          if (cfg_len == '0) done <= 1'b1;
          else st <= S_WREQ;
        end
        S_WREQ: if (req_ack) st <= S_WDAT;
        S_RREQ: if (req_ack) st <= S_RDAT;
        S_WDAT, S_RDAT: if (d_stb) begin
          cnt <= cnt + LW'(1);
          bcnt <= bcnt + BCW'(1);
          if (st == S_RDAT && bad) begin
            if (err_count != EMAX) err_count <= err_count + EW'(1);
            if (err_count == '0) first_bad <= addr;
          end
          if (last_word) begin
            cnt <= '0;
            bcnt <= '0;
            if (st == S_WDAT) st <= S_RREQ;
            else begin
              st <= S_IDLE;
              done <= 1'b1;
            end
          end else if (chunk_end) begin
            bcnt <= '0;
            st <= (st == S_WDAT) ? S_WREQ : S_RREQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module mem_selftest_chk #(
  parameter int AW = 24,
  parameter int EW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [EW-1:0] err_count,
  input logic [AW-1:0] first_bad,
  input logic          req_stb,
  input logic          req_wr,
  input logic [AW-1:0] req_addr,
  input logic          req_ack,
  input logic          d_stb,
  input logic          d_term
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_stb && !req_ack |=> req_stb && $stable(req_wr) && $stable(req_addr)); // R2
  AST_TERM_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
    d_term |-> d_stb); // R5
  AST_NO_TERM_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_stb |-> !d_term); // R5
  AST_ERR_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> err_count >= $past(err_count)); // R6
  AST_FIRST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    err_count == '0 |-> first_bad == '0); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
endmodule

bind mem_selftest mem_selftest_chk #(.AW(AW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err_count(err_count),
  .first_bad(first_bad), .req_stb(req_stb), .req_wr(req_wr), .req_addr(req_addr),
  .req_ack(req_ack), .d_stb(d_stb), .d_term(d_term)
);

// File: tb/sim_mem_selftest.sv
module sim_mem_selftest;
  localparam int AW = 10, LW = 8, EW = 3, BURST = 4;

  logic clk = 0, rst_n = 0, go = 0;
  logic [AW-1:0] cfg_base = '0;
  logic [LW-1:0] cfg_len = '0;
  logic busy, done, req_stb, req_wr, req_ack, d_stb, d_term;
  logic [EW-1:0] err_count;
  logic [AW-1:0] first_bad, req_addr;
  logic [15:0] wdata, rdata;

  always #5 clk = ~clk;

  mem_selftest #(.AW(AW), .LW(LW), .EW(EW), .BURST(BURST)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .cfg_base(cfg_base), .cfg_len(cfg_len),
    .busy(busy), .done(done), .err_count(err_count), .first_bad(first_bad),
    .req_stb(req_stb), .req_wr(req_wr), .req_addr(req_addr), .req_ack(req_ack),
    .d_stb(d_stb), .d_term(d_term), .wdata(wdata), .rdata(rdata));

  // controller model
  logic [15:0] mem [0:(1<<AW)-1];
  logic        m_act = 0, m_wr = 0, saw_rd = 0, order_bad = 0;
  logic [AW-1:0] m_addr = '0, faddr = '0;
  logic [1:0]  mode = 0;
  logic [15:0] gap = '0;
  logic [3:0]  ph = '0;
  logic [1:0]  w = '0;
  int n_req = 0, n_term = 0;

  assign req_ack = req_stb && !m_act && (w == 2'd2);
  assign d_stb   = m_act && !gap[ph];
  assign rdata   = mem[m_addr] ^ (((mode == 2) || (mode == 1 && m_addr == faddr)) ? 16'h0001 : 16'h0);

  always @(posedge clk) begin
    ph <= ph + 4'd1;
    if (req_stb && !m_act) begin
      if (req_ack) begin
        m_act <= 1; m_addr <= req_addr; m_wr <= req_wr; w <= 0; n_req <= n_req + 1;
        if (!req_wr) saw_rd <= 1;
        if (req_wr && saw_rd) order_bad <= 1;
      end else w <= w + 2'd1;
    end
    if (d_stb) begin
      if (m_wr) mem[m_addr] <= wdata;
      m_addr <= m_addr + 1'b1;
      if (d_term) begin m_act <= 0; n_term <= n_term + 1; end
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic clear_model();
    for (int a = 0; a < (1<<AW); a++) mem[a] = 16'h0000;
    n_req = 0; n_term = 0; saw_rd = 0; order_bad = 0;
  endtask

  task automatic pulse_go(input logic [AW-1:0] b, input logic [LW-1:0] l);
    cfg_base = b; cfg_len = l; go = 1;
    @(negedge clk); go = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  function automatic int mem_errs(input int b, input int l);
    int e = 0;
    for (int a = 0; a < (1<<AW); a++) begin
      logic [15:0] x = (a >= b && a < b + l) ? {8'hAD, 8'(a)} : 16'h0;
      if (mem[a] != x) e++;
    end
    return e;
  endfunction

  typedef struct packed {
    logic [AW-1:0] base; logic [LW-1:0] len; logic [15:0] gap;
    logic [1:0] mode; logic [AW-1:0] fa; logic [EW-1:0] xerr; logic [AW-1:0] xfirst;
  } vec_t;
  localparam vec_t VT [6] = '{
    '{10'h050, 8'd100, 16'h0000, 2'd0, 10'h000, 3'd0, 10'h000},
    '{10'h055, 8'd4,   16'hA5A5, 2'd1, 10'h057, 3'd1, 10'h057},
    '{10'h100, 8'd9,   16'h0F0F, 2'd1, 10'h200, 3'd0, 10'h000},
    '{10'h200, 8'd12,  16'h3333, 2'd2, 10'h000, 3'd7, 10'h200},
    '{10'h3F0, 8'd1,   16'hFFFE, 2'd1, 10'h3F0, 3'd1, 10'h3F0},
    '{10'h180, 8'd5,   16'h8001, 2'd1, 10'h184, 3'd1, 10'h184}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit ok;
    clear_model();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req_stb && !d_term, "R1 control outputs", {busy, done, req_stb, d_term}, 0);
    chk(err_count == 0 && first_bad == 0, "R1 status", err_count, 0);
    rst_n = 1;
    @(negedge clk);

    foreach (VT[i]) begin
      int nb;
      clear_model();
      gap = VT[i].gap; mode = VT[i].mode; faddr = VT[i].fa;
      pulse_go(VT[i].base, VT[i].len);
      chk(busy && req_stb && req_wr && req_addr == VT[i].base, "R2 first request", req_addr, VT[i].base);
      wait_done(ok);
      chk(ok && !busy, "R8 done with busy low", {ok, busy}, 2);
      @(negedge clk);
      chk(!done, "R8 done one cycle", done, 0);
      chk(err_count == VT[i].xerr, "R6 error count", err_count, VT[i].xerr);
      chk(first_bad == VT[i].xfirst, "R7 first bad address", first_bad, VT[i].xfirst);
      chk(mem_errs(VT[i].base, VT[i].len) == 0, "R3 R4 memory image", mem_errs(VT[i].base, VT[i].len), 0);
      chk(!order_bad, "R3 write pass before read pass", order_bad, 0);
      nb = 2 * ((VT[i].len + BURST - 1) / BURST);
      chk(n_req == nb && n_term == nb, "R5 bursts and terminates", n_req * 256 + n_term, nb * 256 + nb);
    end

    // R9: go while busy
    clear_model(); gap = 16'h0101; mode = 0;
    pulse_go(10'h020, 8'd8);
    repeat (3) @(negedge clk);
    pulse_go(10'h300, 8'd4);
    wait_done(ok);
    @(negedge clk);
    chk(ok && mem_errs(10'h020, 8) == 0, "R9 second go ignored, window", mem_errs(10'h020, 8), 0);
    chk(n_req == 4, "R9 second go ignored, requests", n_req, 4);

    // R10: zero length
    clear_model();
    pulse_go(10'h040, 8'd0);
    chk(done && !busy && err_count == 0, "R10 immediate done", {done, busy}, 2);
    @(negedge clk);
    chk(n_req == 0 && !req_stb, "R10 no request", n_req, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule